// File: doc/BRIEF.md
# Prescaled Compare-Match Timer

This block is a free-running up-counter for a microcontroller-class subsystem. Its clock is the base tick. A power-of-two prescaler divides that tick, so the counter advances once every 2^p clocks. The counter can be 8, 16, 24 or 32 bits wide and rolls over to zero at the top of the selected width. Four compare channels each hold a match value. A channel raises a sticky flag when the counter steps onto that value, and this includes a value that is only reached after a rollover.

Software drives the block through a small word-addressed register port. Writing a 1 to one of three trigger addresses starts, halts or zeroes the counter. Writes to the size and divider registers configure it. Each channel flag is read at its own address and is cleared by writing a 0 there. Every channel also has a one-clock pulse output, which fires when its flag goes from 0 to 1. Register reads are combinational from the address.

Top module: `pct_timer`

## Requirements
- R1: After reset the counter reads 0, the timer is halted, size reads 0, divider reads 0, all four flags read 0 and no pulse output is high.
- R2: A write with bit 0 set to address 0 (GO) starts counting. The same write to address 1 (HALT) stops it. The same write to address 2 (ZERO) sets the counter to 0 and restarts the prescale phase, and a running timer keeps running. A trigger write with bit 0 clear has no effect.
- R3: The divider (address 4, 4 bits) makes the counter advance once per 2^p clocks, counted from the GO edge after a ZERO. A written value above 9 is stored and read back as 9.
- R4: Size (address 3) encodes 0 = 16-bit, 1 = 8-bit, 2 = 24-bit, 3 = 32-bit. The counter (read at address 5) goes from its all-ones value to 0.
- R5: Channel i (match value at address 8+i, flag at address 12+i) sets its flag on the clock edge where an increment moves the counter onto the match value masked to the current size. A match value below the current count fires only after a rollover.
- R6: A flag stays 1 until software writes a word with bit 0 clear to its address. It then stays 0 until the next match. A write with bit 0 set to a flag address has no effect.
- R7: When a match and a flag-clear write fall on the same edge, the flag ends up 1.
- R8: Output evt_pulse[i] is high for exactly one clock, in the cycle in which flag i first reads 1 after having been 0.
- R9: A halted timer holds both its count and its prescale phase. GO resumes from the held state.
- R10: ZERO on a halted timer leaves it halted at 0, and ZERO never sets a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_pulse | output | 4 | One-clock pulse per channel on a flag rising |

## Verification
The case that needs care is a counter increment that lands on a channel's match value in the same cycle that software writes 0 to that channel's flag. The bench provokes it with the divider at 0 in 8-bit mode, so the count equals the number of edges since GO. It then times the flag-clear write so that it lands on exactly the edge on which the count reaches the match value. The flag must read 1 afterwards with one pulse seen, and a clear one cycle later must read 0. A second channel is sampled one cycle before and one cycle after its match edge, which pins the cycle in which the flag appears.

// File: rtl/pct_pkg.sv
// Package: shared encodings for the prescaled compare-match timer.
// Assumes a 32-bit data path and a 4-bit word address space.
package pct_pkg;

    // Counter size selector, as software writes it
    typedef enum logic [1:0] {
        SZ_16 = 2'd0,
        SZ_8  = 2'd1,
        SZ_24 = 2'd2,
        SZ_32 = 2'd3
    } size_e;

    // Word addresses of the register port
    localparam int A_GO       = 0;
    localparam int A_HALT     = 1;
    localparam int A_ZERO     = 2;
    localparam int A_SIZE     = 3;
    localparam int A_DIV      = 4;
    localparam int A_COUNT    = 5;
    localparam int A_MATCH0   = 8;
    localparam int A_FLAG0    = 12;

    // All-ones mask for the selected counter size
    function automatic logic [31:0] size_mask(input size_e s);
        case (s)
            SZ_8:    return 32'h0000_00FF;
            SZ_24:   return 32'h00FF_FFFF;
            SZ_32:   return 32'hFFFF_FFFF;
            default: return 32'h0000_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/pct_prescale.sv
// Prescale divider: produces a one-clock tick every 2^pre clocks while run
// is high. Assumes pre never exceeds PRE_MAX (the register file saturates it).
// The phase counter is held while halted and zeroed by restart.
module pct_prescale #(
    parameter int PRE_W   = 4,
    parameter int PRE_MAX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    localparam int DIV_W = (PRE_MAX < 1) ? 1 : PRE_MAX;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] phase_mask;

    // Low pre bits of the phase must all be ones for a tick
    always_comb begin
        for (int b = 0; b < DIV_W; b++) begin
            phase_mask[b] = (b < int'(pre));
        end
    end

    assign tick = run && ((phase_q & phase_mask) == phase_mask);

    // Phase counter: zeroed on restart, advances only while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(phase_q)); // R9

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0)); // R2

endmodule

// File: rtl/pct_counter.sv
// Main counter: advances by one on each prescale tick and rolls over at the
// selected size. A zero request overrides a same-cycle tick. The count is
// presented masked to the current size, and the value the next increment
// would take is exported to the compare channels.
module pct_counter #(
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           zero,
    input  pct_pkg::size_e size,
    output logic [DW-1:0]  count,
    output logic [DW-1:0]  mask,
    output logic [DW-1:0]  nxt,
    output logic           step
);
    import pct_pkg::*;

    logic [DW-1:0] cnt_q;
    logic [31:0]   full_mask;

    assign full_mask = size_mask(size);
    assign mask      = full_mask[DW-1:0];
    assign nxt       = (cnt_q + 1'b1) & mask;
    assign step      = tick && !zero;
    assign count     = cnt_q & mask;

    // Count register: zero wins, otherwise step on a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (zero) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= nxt;
        end
    end

    AST_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zero |=> (count == '0)); // R2

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !zero) |=> $stable(cnt_q)); // R9

    AST_ROLL_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (count == mask) && $stable(mask)) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/pct_chan.sv
// One compare channel: a sticky flag set when the counter steps onto the
// masked match value, and a one-clock pulse on the flag's 0-to-1 change.
// A match outranks a same-cycle clear request.
module pct_chan #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [DW-1:0] nxt,
    input  logic [DW-1:0] match,
    input  logic [DW-1:0] mask,
    input  logic          clr_req,
    output logic          flag,
    output logic          pulse
);
    logic hit;

    assign hit = step && (nxt == (match & mask));

    // Sticky flag and rising-edge pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= hit && !flag;
            if (hit) begin
                flag <= 1'b1;
            end else if (clr_req) begin
                flag <= 1'b0;
            end
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R7

    AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag); // R8

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R8

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !hit) |=> (!flag && !pulse)); // R5

endmodule

// File: rtl/pct_timer.sv
// Top of the prescaled compare-match timer. Decodes the word-addressed
// register port into trigger actions and configuration, and instantiates the
// prescaler, the counter and one compare channel per CH_N. The address map
// assumes CH_N <= 4 and DW == 32.
module pct_timer #(
    parameter int CH_N    = 4,
    parameter int DW      = 32,
    parameter int AW      = 4,
    parameter int PRE_W   = 4,
    parameter int PRE_MAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [CH_N-1:0] evt_pulse
);
    import pct_pkg::*;

    localparam logic [PRE_W-1:0] DIV_TOP = PRE_W'(PRE_MAX);

    logic             run_q;
    size_e            size_q;
    logic [PRE_W-1:0] div_q;
    logic [DW-1:0]    match_q [CH_N];
    logic [CH_N-1:0]  flag;
    logic [CH_N-1:0]  clr_req;

    logic             wr_go, wr_halt, wr_zero, wr_size, wr_div;
    logic             tick, step;
    logic [DW-1:0]    count, mask, nxt;
    logic [PRE_W-1:0] div_wr;

    // Trigger and configuration write decode
    always_comb begin
        wr_go   = bus_wr && (int'(bus_addr) == A_GO)   && bus_wdata[0];
        wr_halt = bus_wr && (int'(bus_addr) == A_HALT) && bus_wdata[0];
        wr_zero = bus_wr && (int'(bus_addr) == A_ZERO) && bus_wdata[0];
        wr_size = bus_wr && (int'(bus_addr) == A_SIZE);
        wr_div  = bus_wr && (int'(bus_addr) == A_DIV);
    end

    // Divider value clipped to the supported maximum
    assign div_wr = (bus_wdata[PRE_W-1:0] > DIV_TOP) ? DIV_TOP
                                                     : bus_wdata[PRE_W-1:0];

    // Run state: GO sets, HALT clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (wr_halt) begin
            run_q <= 1'b0;
        end else if (wr_go) begin
            run_q <= 1'b1;
        end
    end

    // Size and divider configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SZ_16;
            div_q  <= '0;
        end else begin
            if (wr_size) size_q <= size_e'(bus_wdata[1:0]);
            if (wr_div)  div_q  <= div_wr;
        end
    end

    pct_prescale #(
        .PRE_W   (PRE_W),
        .PRE_MAX (PRE_MAX)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .restart (wr_zero),
        .pre     (div_q),
        .tick    (tick)
    );

    pct_counter #(
        .DW (DW)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .zero  (wr_zero),
        .size  (size_q),
        .count (count),
        .mask  (mask),
        .nxt   (nxt),
        .step  (step)
    );

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        // Match value register for this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                match_q[i] <= '0;
            end else if (bus_wr && (int'(bus_addr) == A_MATCH0 + i)) begin
                match_q[i] <= bus_wdata;
            end
        end

        assign clr_req[i] = bus_wr && (int'(bus_addr) == A_FLAG0 + i)
                            && !bus_wdata[0];

        pct_chan #(
            .DW (DW)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step),
            .nxt     (nxt),
            .match   (match_q[i]),
            .mask    (mask),
            .clr_req (clr_req[i]),
            .flag    (flag[i]),
            .pulse   (evt_pulse[i])
        );
    end

    // Combinational read mux
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            A_SIZE:  bus_rdata = DW'(size_q);
            A_DIV:   bus_rdata = DW'(div_q);
            A_COUNT: bus_rdata = count;
            default: begin
                for (int i = 0; i < CH_N; i++) begin
                    if (int'(bus_addr) == A_MATCH0 + i) bus_rdata = match_q[i];
                    if (int'(bus_addr) == A_FLAG0 + i)  bus_rdata = DW'(flag[i]);
                end
            end
        endcase
    end

    AST_DIV_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= DIV_TOP); // R3

    AST_GO_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !wr_halt) |=> run_q); // R2

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_halt |=> !run_q); // R2

    AST_HALTED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !tick); // R9

    AST_ZERO_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && (flag == '0)) |=> (flag == '0)); // R10

endmodule

// File: tb/sim_pct_timer.sv
// Self-checking bench for pct_timer: sweeps divider and run lengths in 8-bit
// mode and covers rollover, sticky flags, same-cycle match/clear and triggers.
module sim_pct_timer;
    import pct_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  evt_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int pcnt [4] = '{default: 0};

    always #2 clk = ~clk;

    pct_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_pulse (evt_pulse)
    );

    // Count pulses per channel, sampled away from the active edge
    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) if (evt_pulse[i]) pcnt[i]++;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Called at a negedge; takes effect at the next posedge; returns at negedge
    task automatic wr(input int a, input logic [31:0] d);
        bus_addr  = 4'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 4'(a);
        #1;
        d = bus_rdata;
    endtask

    // GO, g further negedges, HALT: exactly g+1 running edges
    task automatic run_seg(input int g);
        wr(A_GO, 1);
        repeat (g) @(negedge clk);
        wr(A_HALT, 1);
    endtask

    task automatic clear_flags();
        for (int i = 0; i < 4; i++) wr(A_FLAG0 + i, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base [4];
        int gl [6] = '{0, 3, 17, 255, 300, 700};
        int mm [4] = '{2, 128, 255, 0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_COUNT, v); chk("R1", "count", v, 0);
        rd(A_SIZE, v);  chk("R1", "size", v, 0);
        rd(A_DIV, v);   chk("R1", "div", v, 0);
        for (int i = 0; i < 4; i++) begin
            rd(A_FLAG0 + i, v); chk("R1", "flag", v, 0);
        end
        chk("R1", "pulses", 32'(evt_pulse), 0);
        repeat (4) @(negedge clk);
        rd(A_COUNT, v); chk("R1", "halted after reset", v, 0);

        // R3 divider saturation
        wr(A_DIV, 15); rd(A_DIV, v); chk("R3", "div sat", v, 9);
        wr(A_DIV, 5);  rd(A_DIV, v); chk("R3", "div 5", v, 5);

        // Sweep: 8-bit, divider 0..3, several run lengths, halt/resume
        wr(A_SIZE, 1);
        wr(A_MATCH0 + 0, 2);
        wr(A_MATCH0 + 1, 32'h80);
        wr(A_MATCH0 + 2, 32'h1FF);
        wr(A_MATCH0 + 3, 0);
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 6; k++) begin
                int g, g2, tot;
                g  = gl[k];
                g2 = g / 2 + 5;
                wr(A_DIV, p);
                wr(A_ZERO, 1);
                clear_flags();
                for (int i = 0; i < 4; i++) base[i] = pcnt[i];
                run_seg(g);
                rd(A_COUNT, v); chk("R3", "prescaled count", v, ((g + 1) >> p) & 255);
                repeat (10) @(negedge clk);
                rd(A_COUNT, v); chk("R9", "held count", v, ((g + 1) >> p) & 255);
                run_seg(g2);
                tot = ((g + 1) + (g2 + 1)) >> p;
                rd(A_COUNT, v); chk("R9", "resumed count", v, tot & 255);
                for (int i = 0; i < 4; i++) begin
                    int e;
                    e = (mm[i] == 0) ? (tot >= 256) : (tot >= mm[i]);
                    rd(A_FLAG0 + i, v); chk("R5", "sweep flag", v, e);
                    chk("R8", "sweep pulses", pcnt[i] - base[i], e);
                end
            end
        end

        // R7 same-edge match and clear; R5 exact match cycle
        wr(A_DIV, 0);
        wr(A_MATCH0 + 0, 20);
        wr(A_MATCH0 + 1, 30);
        wr(A_ZERO, 1);
        clear_flags();
        for (int i = 0; i < 4; i++) base[i] = pcnt[i];
        wr(A_GO, 1);
        repeat (19) @(negedge clk);
        wr(A_FLAG0, 0);
        rd(A_FLAG0, v); chk("R7", "set beats clear", v, 1);
        chk("R8", "one pulse ch0", pcnt[0] - base[0], 1);
        wr(A_FLAG0, 0);
        rd(A_FLAG0, v); chk("R6", "cleared flag", v, 0);
        repeat (8) @(negedge clk);
        rd(A_FLAG0 + 1, v); chk("R5", "before match", v, 0);
        @(negedge clk);
        rd(A_FLAG0 + 1, v); chk("R5", "at match", v, 1);
        rd(A_COUNT, v);     chk("R5", "count at match", v, 30);
        rd(A_FLAG0, v);     chk("R6", "stays clear", v, 0);
        wr(A_FLAG0 + 1, 1);
        rd(A_FLAG0 + 1, v); chk("R6", "write 1 ignored", v, 1);
        wr(A_HALT, 1);

        // R5 match below current count needs a rollover
        wr(A_ZERO, 1);
        run_seg(99);
        clear_flags();
        wr(A_MATCH0 + 2, 50);
        run_seg(159);
        rd(A_COUNT, v);     chk("R4", "8-bit wrap", v, 4);
        rd(A_FLAG0 + 2, v); chk("R5", "below count not yet", v, 0);
        run_seg(49);
        rd(A_FLAG0 + 2, v); chk("R5", "after wrap", v, 1);

        // R4 16-bit rollover and masked match
        wr(A_SIZE, 0);
        wr(A_MATCH0 + 3, 32'h0001_0003);
        wr(A_ZERO, 1);
        clear_flags();
        run_seg(65539);
        rd(A_COUNT, v);     chk("R4", "16-bit wrap", v, 4);
        rd(A_FLAG0 + 3, v); chk("R4", "masked match", v, 1);

        // R4 wider sizes do not roll at 8 bits
        wr(A_SIZE, 2); rd(A_SIZE, v); chk("R4", "size 24", v, 2);
        wr(A_ZERO, 1); run_seg(299);
        rd(A_COUNT, v); chk("R4", "24-bit count", v, 300);
        wr(A_SIZE, 3); rd(A_SIZE, v); chk("R4", "size 32", v, 3);
        wr(A_DIV, 15);
        wr(A_ZERO, 1); run_seg(1023);
        rd(A_COUNT, v); chk("R3", "divide by 512", v, 2);

        // R10 ZERO while halted; R2 zero-data trigger ignored
        wr(A_SIZE, 1);
        wr(A_DIV, 0);
        wr(A_MATCH0 + 3, 0);
        clear_flags();
        wr(A_ZERO, 1);
        rd(A_COUNT, v);     chk("R10", "zeroed", v, 0);
        rd(A_FLAG0 + 3, v); chk("R10", "no flag from zero", v, 0);
        wr(A_GO, 0);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v);     chk("R2", "go with 0 ignored", v, 0);

        // R2 ZERO while running keeps running
        wr(A_GO, 1);
        repeat (9) @(negedge clk);
        wr(A_ZERO, 1);
        rd(A_COUNT, v); chk("R2", "zero while running", v, 0);
        @(negedge clk);
        rd(A_COUNT, v); chk("R2", "still running", v, 1);
        wr(A_HALT, 0);
        rd(A_COUNT, v); chk("R2", "halt with 0 ignored", v, 2);
        wr(A_HALT, 1);
        rd(A_COUNT, v); chk("R2", "halted", v, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule